// File: doc/BRIEF.md
# Synchronous Rectifier Gate Timing Estimator

This block is a per-channel digital timer that drives the gate of one synchronous-rectifier switch in a resonant converter. Its input is a digitized comparator bit, `det_low`. The bit is high while the switch's drain voltage sits near zero, which means the body diode or the switch is conducting. The block counts how many clock cycles the bit stays high in each switching period and stores that count as the conduction time. In the following period it uses the stored count to predict when the gate must turn off.

The gate turns on after a fixed delay once conduction is seen. The delay has two parts: a debounce and a propagation allowance. The on-time budget is the previous conduction count minus a programmable dead time, minus any shrink amount requested by an external shrink controller. The budget is then limited by a maximum on-time and by a growth limit relative to the previous pulse. A minimum on-time (blanking) masks early comparator deassertion. After every turn-off, a re-trigger inhibit window applies, and its length depends on the selected frequency mode. When the global enable is low, the gate is held off and all stored history is dropped.

All times are counted in cycles of the block clock with 16-bit saturating counters. The default parameters assume a 100 MHz clock: 150 ns debounce, 350 ns total turn-on delay, 300 ns blanking, 10.5 us maximum on-time, and 2.1 us / 1.45 us inhibit.

Top module: `sr_gate_timer`

## Requirements
- R1: While `rst` is high or `en` is low, `gate` is 0 from the next clock edge and `cond_time` reads 0; all stored history is discarded.
- R2: One cycle after `det_low` is first sampled low following a high run, `cond_time` equals the number of clock edges at which `det_low` was sampled high in that run.
- R3: No gate pulse occurs during the first high run of `det_low` after reset or after `en` rises, because no prior measurement exists yet.
- R4: The gate rises at the clock edge where `det_low` has been sampled high for DEB_CYC+PD_CYC consecutive edges; a shorter high run never turns the gate on.
- R5: The pulse budget is `cond_time` (previous run) minus `dead_cyc` minus `shrink_cyc`, floored at 0. A pulse lasts at most budget cycles, and a budget of 0 produces no pulse.
- R6: No pulse is longer than MAX_ON_CYC cycles.
- R7: If `det_low` falls before the gate has been high for BLANK_CYC cycles, the gate stays high until it has been high for BLANK_CYC cycles, unless the budget ends the pulse earlier.
- R8: Once blanking has elapsed, the first edge at which `det_low` is sampled low turns the gate off.
- R9: After a turn-off, no new pulse can start for INH_LF_CYC edges when `hf_mode` is 0, or for INH_HF_CYC edges when `hf_mode` is 1. A run whose turn-on point falls inside this window produces no pulse.
- R10: When a previous pulse exists, the budget is also capped at floor(previous pulse length × GROW_NUM / GROW_DEN), which is 140% with the defaults.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; all timing is counted in its cycles |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Global enable; low forces the gate off and clears history |
| det_low | input | 1 | Comparator bit, high while the drain voltage is near zero |
| dead_cyc | input | 16 | Dead time subtracted from the prediction, in cycles |
| shrink_cyc | input | 16 | Extra reduction requested by the shrink controller, in cycles |
| hf_mode | input | 1 | 1 selects the short re-trigger inhibit, 0 the long one |
| gate | output | 1 | Gate drive request for the rectifier switch |
| cond_time | output | 16 | Conduction length of the last completed high run, in cycles |

## Verification
The bench builds the block with a 3-cycle debounce, a 2-cycle propagation allowance, 4-cycle blanking, a 40-cycle maximum on-time, and inhibit windows of 12 and 6 cycles. With these values every limiter can be reached with runs of a few dozen cycles: a budget shorter than the run, blanking that stretches a 6-cycle run, the growth cap and the maximum cap ending ramping pulses, and a short gap between runs that is blocked in low-frequency mode but allowed in high-frequency mode. Expected pulse lengths come from a cycle-counted model of the requirements, and a monitor compares them against each observed pulse.

// File: rtl/sr_gate_pkg.sv
package sr_gate_pkg;

    localparam int CNT_W = 16;
    localparam int PROD_W = 2 * CNT_W;

    typedef logic [CNT_W-1:0] cnt_t;

    typedef enum logic [1:0] {
        GS_IDLE = 2'd0,
        GS_ON   = 2'd1,
        GS_INH  = 2'd2
    } gate_state_e;

    // Increment that sticks at the all-ones value.
    function automatic cnt_t sat_inc(input cnt_t v);
        return (v == '1) ? v : v + cnt_t'(1);
    endfunction

    // Subtraction floored at zero.
    function automatic cnt_t sub_floor(input cnt_t a, input cnt_t b);
        return (a > b) ? a - b : '0;
    endfunction

    function automatic cnt_t min2(input cnt_t a, input cnt_t b);
        return (a < b) ? a : b;
    endfunction

    // Ratio limit on the previous pulse, saturated to the counter width.
    function automatic cnt_t grow_cap(input cnt_t prev, input int num, input int den);
        logic [PROD_W-1:0] prod;
        logic [PROD_W-1:0] quo;
        prod = PROD_W'(prev) * PROD_W'(num);
        quo  = prod / PROD_W'(den);
        return (quo > PROD_W'({CNT_W{1'b1}})) ? '1 : quo[CNT_W-1:0];
    endfunction

endpackage

// File: rtl/sr_cond_meter.sv
module sr_cond_meter
    import sr_gate_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic det_low,
    output cnt_t low_run,
    output cnt_t cond_q,
    output logic cond_valid
);

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            low_run    <= '0;
            cond_q     <= '0;
            cond_valid <= 1'b0;
        end else if (det_low) begin
            low_run <= sat_inc(low_run);
        end else begin
            low_run <= '0;
            if (low_run != '0) begin
                cond_q     <= low_run;
                cond_valid <= 1'b1;
            end
        end
    end

    // A new measurement only appears right after a run has ended.
    assert_cond_on_fall_R2: assert property (@(posedge clk) disable iff (rst)
        (en && $past(en) && !$stable(cond_q)) |-> (!$past(det_low) && $past(low_run) != '0));

    // Disabling drops the stored measurement.
    assert_cond_cleared_R1: assert property (@(posedge clk) disable iff (rst)
        !en |=> (cond_q == '0 && !cond_valid));

endmodule

// File: rtl/sr_on_target.sv
module sr_on_target
    import sr_gate_pkg::*;
#(
    parameter int MAX_ON_CYC = 1050,
    parameter int GROW_NUM   = 7,
    parameter int GROW_DEN   = 5
) (
    input  cnt_t cond_q,
    input  logic cond_valid,
    input  cnt_t dead_cyc,
    input  cnt_t shrink_cyc,
    input  cnt_t prev_on,
    input  logic prev_valid,
    output cnt_t tgt,
    output logic arm
);

    localparam cnt_t MAX_ON = cnt_t'(MAX_ON_CYC);

    cnt_t base;
    cnt_t capped;

    always_comb begin
        base   = sub_floor(sub_floor(cond_q, dead_cyc), shrink_cyc);
        capped = min2(base, MAX_ON);
        if (prev_valid) begin
            capped = min2(capped, grow_cap(prev_on, GROW_NUM, GROW_DEN));
        end
        tgt = capped;
        arm = cond_valid && (capped != '0);
    end

endmodule

// File: rtl/sr_gate_fsm.sv
module sr_gate_fsm
    import sr_gate_pkg::*;
#(
    parameter int ON_DLY     = 35,
    parameter int BLANK_CYC  = 30,
    parameter int MAX_ON_CYC = 1050,
    parameter int INH_LF_CYC = 210,
    parameter int INH_HF_CYC = 145,
    parameter int GROW_NUM   = 7,
    parameter int GROW_DEN   = 5
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic det_low,
    input  logic hf_mode,
    input  cnt_t low_run,
    input  cnt_t tgt,
    input  logic arm,
    output logic gate,
    output cnt_t prev_on,
    output logic prev_valid
);

    localparam cnt_t TRIG_AT = cnt_t'(ON_DLY - 1);
    localparam cnt_t BLANK   = cnt_t'(BLANK_CYC);
    localparam cnt_t INH_LF  = cnt_t'(INH_LF_CYC);
    localparam cnt_t INH_HF  = cnt_t'(INH_HF_CYC);

    gate_state_e st;
    cnt_t        on_cnt;
    cnt_t        inh_cnt;
    cnt_t        tgt_q;
    logic        end_pulse;

    assign end_pulse = (on_cnt >= tgt_q) || (!det_low && on_cnt >= BLANK);

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            st         <= GS_IDLE;
            gate       <= 1'b0;
            on_cnt     <= '0;
            inh_cnt    <= '0;
            tgt_q      <= '0;
            prev_on    <= '0;
            prev_valid <= 1'b0;
        end else begin
            unique case (st)
                GS_IDLE: begin
                    if (det_low && arm && low_run == TRIG_AT) begin
                        st     <= GS_ON;
                        gate   <= 1'b1;
                        on_cnt <= cnt_t'(1);
                        tgt_q  <= tgt;
                    end
                end
                GS_ON: begin
                    if (end_pulse) begin
                        st         <= GS_INH;
                        gate       <= 1'b0;
                        prev_on    <= on_cnt;
                        prev_valid <= 1'b1;
                        inh_cnt    <= hf_mode ? INH_HF : INH_LF;
                    end else begin
                        on_cnt <= sat_inc(on_cnt);
                    end
                end
                GS_INH: begin
                    if (inh_cnt <= cnt_t'(1)) st <= GS_IDLE;
                    else inh_cnt <= inh_cnt - cnt_t'(1);
                end
                default: st <= GS_IDLE;
            endcase
        end
    end

    assert_off_when_disabled_R1: assert property (@(posedge clk) disable iff (rst)
        !en |=> !gate);

    assert_needs_history_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(gate) |-> $past(arm));

    assert_turn_on_delay_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(gate) |-> (low_run == cnt_t'(ON_DLY)));

    assert_within_budget_R5: assert property (@(posedge clk) disable iff (rst)
        gate |-> (on_cnt <= tgt_q));

    assert_max_on_R6: assert property (@(posedge clk) disable iff (rst)
        gate |-> (on_cnt <= cnt_t'(MAX_ON_CYC)));

    assert_blanking_R7: assert property (@(posedge clk) disable iff (rst)
        (gate && en && on_cnt < BLANK && on_cnt < tgt_q) |=> gate);

    assert_inhibit_R9: assert property (@(posedge clk) disable iff (rst)
        (st == GS_INH) |=> !gate);

    assert_growth_R10: assert property (@(posedge clk) disable iff (rst)
        (st == GS_ON && prev_valid) |-> (int'(tgt_q) * GROW_DEN <= int'(prev_on) * GROW_NUM));

endmodule

// File: rtl/sr_gate_timer.sv
module sr_gate_timer
    import sr_gate_pkg::*;
#(
    parameter int DEB_CYC    = 15,
    parameter int PD_CYC     = 20,
    parameter int BLANK_CYC  = 30,
    parameter int MAX_ON_CYC = 1050,
    parameter int INH_LF_CYC = 210,
    parameter int INH_HF_CYC = 145,
    parameter int GROW_NUM   = 7,
    parameter int GROW_DEN   = 5
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              en,
    input  logic                              det_low,
    input  logic [sr_gate_pkg::CNT_W-1:0]     dead_cyc,
    input  logic [sr_gate_pkg::CNT_W-1:0]     shrink_cyc,
    input  logic                              hf_mode,
    output logic                              gate,
    output logic [sr_gate_pkg::CNT_W-1:0]     cond_time
);

    localparam int ON_DLY = DEB_CYC + PD_CYC;

    cnt_t low_run;
    cnt_t cond_q;
    logic cond_valid;
    cnt_t prev_on;
    logic prev_valid;
    cnt_t tgt;
    logic arm;

    sr_cond_meter u_meter (
        .clk        (clk),
        .rst        (rst),
        .en         (en),
        .det_low    (det_low),
        .low_run    (low_run),
        .cond_q     (cond_q),
        .cond_valid (cond_valid)
    );

    sr_on_target #(
        .MAX_ON_CYC (MAX_ON_CYC),
        .GROW_NUM   (GROW_NUM),
        .GROW_DEN   (GROW_DEN)
    ) u_target (
        .cond_q     (cond_q),
        .cond_valid (cond_valid),
        .dead_cyc   (dead_cyc),
        .shrink_cyc (shrink_cyc),
        .prev_on    (prev_on),
        .prev_valid (prev_valid),
        .tgt        (tgt),
        .arm        (arm)
    );

    sr_gate_fsm #(
        .ON_DLY     (ON_DLY),
        .BLANK_CYC  (BLANK_CYC),
        .MAX_ON_CYC (MAX_ON_CYC),
        .INH_LF_CYC (INH_LF_CYC),
        .INH_HF_CYC (INH_HF_CYC),
        .GROW_NUM   (GROW_NUM),
        .GROW_DEN   (GROW_DEN)
    ) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .en         (en),
        .det_low    (det_low),
        .hf_mode    (hf_mode),
        .low_run    (low_run),
        .tgt        (tgt),
        .arm        (arm),
        .gate       (gate),
        .prev_on    (prev_on),
        .prev_valid (prev_valid)
    );

    assign cond_time = cond_q;

endmodule

// File: tb/sr_gate_timer_tb.sv
module sr_gate_timer_tb;

    localparam int CLK_PERIOD = 10;
    localparam int DEB = 3;
    localparam int PD = 2;
    localparam int ON_DLY = DEB + PD;
    localparam int BLANK = 4;
    localparam int MAXON = 40;
    localparam int INH_LF = 12;
    localparam int INH_HF = 6;
    localparam int GNUM = 7;
    localparam int GDEN = 5;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en = 1'b1;
    logic        det_low = 1'b0;
    logic [15:0] dead_cyc = 16'd0;
    logic [15:0] shrink_cyc = 16'd0;
    logic        hf_mode = 1'b0;
    logic        gate;
    logic [15:0] cond_time;

    int tests = 0;
    int fails = 0;

    // bench-side model state
    int t = 0;
    int m_cond = 0;
    bit m_valid = 0;
    int m_prev = 0;
    bit m_prev_valid = 0;
    int last_off = -1000;
    int last_inh = 0;
    string cur_tag = "R1";

    int    q_len[$];
    string q_tag[$];
    int    run_len = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sr_gate_timer #(
        .DEB_CYC    (DEB),
        .PD_CYC     (PD),
        .BLANK_CYC  (BLANK),
        .MAX_ON_CYC (MAXON),
        .INH_LF_CYC (INH_LF),
        .INH_HF_CYC (INH_HF),
        .GROW_NUM   (GNUM),
        .GROW_DEN   (GDEN)
    ) u_dut (
        .clk        (clk),
        .rst        (rst),
        .en         (en),
        .det_low    (det_low),
        .dead_cyc   (dead_cyc),
        .shrink_cyc (shrink_cyc),
        .hf_mode    (hf_mode),
        .gate       (gate),
        .cond_time  (cond_time)
    );

    task automatic check(input string tag, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        t++;
    endtask

    // Monitor: measures each gate pulse and compares with the scoreboard.
    always @(negedge clk) begin
        if (gate) begin
            run_len++;
        end else if (run_len > 0) begin
            tests++;
            if (q_len.size() == 0) begin
                fails++;
                $display("FAIL %s: actual pulse %0d expected no pulse", cur_tag, run_len);
            end else begin
                automatic int    e = q_len.pop_front();
                automatic string g = q_tag.pop_front();
                if (e != run_len) begin
                    fails++;
                    $display("FAIL %s: actual pulse %0d expected %0d", g, run_len, e);
                end
            end
            run_len = 0;
        end
    end

    // Driver: one switching period with L edges of conduction, then H edges without.
    task automatic run_cycle(input int L, input int H, input string tag);
        int e0;
        int tgt;
        int pulse;
        int inh;
        e0 = t;
        cur_tag = tag;
        if (m_valid && L >= ON_DLY) begin
            tgt = m_cond - int'(dead_cyc) - int'(shrink_cyc);
            if (tgt < 0) tgt = 0;
            if (tgt > MAXON) tgt = MAXON;
            if (m_prev_valid && tgt > (m_prev * GNUM) / GDEN) tgt = (m_prev * GNUM) / GDEN;
            if (tgt > 0 && (e0 + ON_DLY - 1 >= last_off + last_inh + 1)) begin
                pulse = (L - ON_DLY + 1 > BLANK) ? L - ON_DLY + 1 : BLANK;
                if (tgt < pulse) pulse = tgt;
                q_len.push_back(pulse);
                q_tag.push_back(tag);
                inh = hf_mode ? INH_HF : INH_LF;
                last_off = e0 + ON_DLY - 1 + pulse;
                last_inh = inh;
                m_prev = pulse;
                m_prev_valid = 1;
            end
        end
        det_low = 1'b1;
        repeat (L) tick();
        det_low = 1'b0;
        tick();
        check({tag, " R2 cond_time"}, int'(cond_time), L);
        m_cond = L;
        m_valid = 1;
        repeat (H - 1) tick();
    endtask

    initial begin
        repeat (3) tick();
        check("R1 gate in reset", int'(gate), 0);
        check("R1 cond in reset", int'(cond_time), 0);
        rst = 1'b0;
        repeat (4) tick();

        dead_cyc = 16'd6;
        run_cycle(30, 20, "R3 first period");
        run_cycle(30, 20, "R5 dead time budget");
        run_cycle(30, 20, "R5 steady");
        shrink_cyc = 16'd5;
        run_cycle(30, 20, "R5 shrink applied");
        shrink_cyc = 16'd0;
        dead_cyc = 16'd3;
        run_cycle(40, 20, "R10 growth cap");
        run_cycle(60, 20, "R10 growth cap ramp");
        run_cycle(60, 20, "R6 max on-time");
        run_cycle(20, 20, "R8 early turn-off");
        run_cycle(6, 20, "R7 blanking");
        run_cycle(4, 20, "R4 short run ignored");
        dead_cyc = 16'd5;
        run_cycle(10, 20, "R5 zero budget");
        dead_cyc = 16'd3;
        run_cycle(30, 20, "R10 small previous pulse");

        // disable and re-enable
        en = 1'b0;
        repeat (3) tick();
        check("R1 gate disabled", int'(gate), 0);
        check("R1 cond disabled", int'(cond_time), 0);
        en = 1'b1;
        m_valid = 0;
        m_prev_valid = 0;
        m_cond = 0;
        last_off = -1000;
        repeat (2) tick();

        run_cycle(30, 20, "R3 first after enable");
        dead_cyc = 16'd0;
        run_cycle(30, 2, "R8 long pulse");
        run_cycle(30, 2, "R9 blocked low-frequency");
        hf_mode = 1'b1;
        run_cycle(30, 3, "R9 setup high-frequency");
        run_cycle(30, 20, "R9 allowed high-frequency");
        hf_mode = 1'b0;

        repeat (20) tick();
        check("R1 idle gate", int'(gate), 0);
        check("R9 all expected pulses seen", q_len.size(), 0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL R1: watchdog actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule